// File: doc/BRIEF.md
# Two-Stage Coded Clock Divider

This block derives a slower clock from a fast input clock through two dividers in series. The first divider takes a 3-bit code that picks one of six ratios between 4 and 11. The second divider takes a 7-bit field. Its ratio is the field plus one, and any odd result above one is raised to the next even value. All counting runs in the input clock domain. The divided output leaves the block from a single register, so it has no glitches.

Software-style settings enter through a pair of shadow registers. An apply strobe loads them and raises a pending flag. The running dividers take the shadow contents only when that flag is consumed, and both ratios change in the same cycle. A freeze input holds the pending flag, so the codes can be rewritten any number of times while the output keeps its current rate. When the pending flag is consumed, both divider counters restart from zero. An output-enable input keeps the output low and releases it only at the start of a whole output period.

Top module: `cdv_two_stage`

## Requirements
- R1: The first-stage code maps as follows: 000→4, 001→5, 010→6, 011→7, 101→9 and 111→11. With a second-stage ratio of one, the output period equals that ratio and the high phase lasts ratio/2 input cycles, rounded down.
- R2: Codes 100 and 110 are not valid. When such a code is applied, the first-stage ratio stays at its previous value, while the second-stage field from the same apply still takes effect. The code_err output goes to 1 and stays at 1 until reset.
- R3: The second-stage ratio is the 7-bit field plus one. A field of 0 gives 1 and a field of 127 gives 128. An odd sum above one is raised by one, so a field of 2 gives 4 and a field of 126 gives 128.
- R4: When the second-stage ratio is even, the high and low phases of the output are equal, each half the total ratio. When the second-stage ratio is one and the first-stage ratio is odd, the high phase is one input cycle shorter than the low phase.
- R5: Changing hs_code or n1_code without an apply strobe leaves the output period unchanged.
- R6: An apply strobe sampled at a clock edge sets apply_pend after that edge. With freeze low, the flag clears after the following edge, and the new settings are active from that same edge.
- R7: While freeze is high, apply_pend stays set and the output keeps its old period. The new settings take effect on the first edge at which freeze is low.
- R8: While out_en is low, clk_out is low from the next edge onward. After out_en rises, the first high phase of clk_out is a full-length one.
- R9: When new settings take effect at an edge, both counters restart. clk_out is high after the next edge and stays high for one full high phase of the new ratio.
- R10: After reset, clk_out, apply_pend and code_err are 0, and the active ratios are 4 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| out_en | input | 1 | Output enable; when low, the output is held low |
| freeze | input | 1 | Holds a pending apply so that it does not take effect |
| apply | input | 1 | One-cycle strobe that loads the shadow codes and requests an update |
| hs_code | input | 3 | First-stage ratio code |
| n1_code | input | 7 | Second-stage field (ratio minus one) |
| clk_out | output | 1 | Divided clock, driven from a register |
| apply_pend | output | 1 | Set while an applied update is waiting to take effect |
| code_err | output | 1 | Sticky flag for an invalid first-stage code |

## Verification
The properties assume that every input is synchronous to clk and changes only away from its rising edge. They also assume apply is not raised again in the cycle the pending flag is consumed; the pending-clear property excludes that case through its antecedent. The stimulus changes inputs only on falling edges and pulses apply for exactly one cycle. It waits for an output period to settle before it measures high and low phases by sampling on falling edges.

// File: rtl/cdv_pkg.sv
`timescale 1ns/1ps
package cdv_pkg;
  localparam int HS_CODE_W  = 3;
  localparam int HS_RATIO_W = 4;

  // Returns {valid, ratio}; codes 100 and 110 are not valid.
  function automatic logic [HS_RATIO_W:0] hs_decode(input logic [HS_CODE_W-1:0] code);
    logic [HS_RATIO_W:0] r;
    case (code)
      3'b000:  r = {1'b1, HS_RATIO_W'(4)};
      3'b001:  r = {1'b1, HS_RATIO_W'(5)};
      3'b010:  r = {1'b1, HS_RATIO_W'(6)};
      3'b011:  r = {1'b1, HS_RATIO_W'(7)};
      3'b101:  r = {1'b1, HS_RATIO_W'(9)};
      3'b111:  r = {1'b1, HS_RATIO_W'(11)};
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cdv_rst_sync.sv
`timescale 1ns/1ps
module cdv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb sync_n = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_n;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cdv_apply_ctl.sv
`timescale 1ns/1ps
module cdv_apply_ctl
  import cdv_pkg::*;
#(
  parameter int N1_W = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  apply,
  input  logic                  freeze,
  input  logic [HS_CODE_W-1:0]  hs_code,
  input  logic [N1_W-1:0]       n1_code,
  output logic                  commit,
  output logic                  pend,
  output logic                  err,
  output logic [HS_RATIO_W-1:0] hs_ratio,
  output logic [N1_W:0]         n1_ratio
);
  localparam int NR_W = N1_W + 1;

  logic [HS_CODE_W-1:0]  sh_hs_q, sh_hs_n;
  logic [N1_W-1:0]       sh_n1_q, sh_n1_n;
  logic                  pend_q, pend_n;
  logic                  err_q, err_n;
  logic [HS_RATIO_W-1:0] hs_r_q, hs_r_n;
  logic [NR_W-1:0]       n1_r_q, n1_r_n;
  logic [HS_RATIO_W:0]   dec;
  logic [NR_W-1:0]       n1_plus, n1_even;

  assign commit = pend_q & ~freeze;

  always_comb begin
    dec     = hs_decode(sh_hs_q);
    n1_plus = {1'b0, sh_n1_q} + NR_W'(1);
    n1_even = (n1_plus[0] && (n1_plus != NR_W'(1))) ? n1_plus + NR_W'(1) : n1_plus;

    sh_hs_n = sh_hs_q;
    sh_n1_n = sh_n1_q;
    pend_n  = pend_q;
    err_n   = err_q;
    hs_r_n  = hs_r_q;
    n1_r_n  = n1_r_q;

    if (commit) begin
      if (dec[HS_RATIO_W]) hs_r_n = dec[HS_RATIO_W-1:0];
      else                 err_n  = 1'b1;
      n1_r_n = n1_even;
      pend_n = 1'b0;
    end
    if (apply) begin
      sh_hs_n = hs_code;
      sh_n1_n = n1_code;
      pend_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_hs_q <= '0;
      sh_n1_q <= '0;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
      hs_r_q  <= HS_RATIO_W'(4);
      n1_r_q  <= NR_W'(1);
    end else begin
      sh_hs_q <= sh_hs_n;
      sh_n1_q <= sh_n1_n;
      pend_q  <= pend_n;
      err_q   <= err_n;
      hs_r_q  <= hs_r_n;
      n1_r_q  <= n1_r_n;
    end
  end

  assign pend     = pend_q;
  assign err      = err_q;
  assign hs_ratio = hs_r_q;
  assign n1_ratio = n1_r_q;
endmodule

// File: rtl/cdv_stage_cnt.sv
`timescale 1ns/1ps
module cdv_stage_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          adv,
  input  logic [CW-1:0] ratio,
  output logic [CW-1:0] cnt,
  output logic          wrap,
  output logic          hi
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          last;
  logic          cnt_en;

  always_comb begin
    last   = (cnt_q == ratio - CW'(1));
    cnt_en = restart | adv;
    if (restart)   cnt_n = '0;
    else if (last) cnt_n = '0;
    else           cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign cnt  = cnt_q;
  assign wrap = adv & last;
  assign hi   = (cnt_q < (ratio >> 1));
endmodule

// File: rtl/cdv_two_stage.sv
`timescale 1ns/1ps
module cdv_two_stage
  import cdv_pkg::*;
#(
  parameter int N1_W = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 out_en,
  input  logic                 freeze,
  input  logic                 apply,
  input  logic [HS_CODE_W-1:0] hs_code,
  input  logic [N1_W-1:0]      n1_code,
  output logic                 clk_out,
  output logic                 apply_pend,
  output logic                 code_err
);
  localparam int NR_W = N1_W + 1;

  logic                  rst_sync_n;
  logic                  commit;
  logic [HS_RATIO_W-1:0] hs_ratio_q;
  logic [NR_W-1:0]       n1_ratio_q;
  logic [HS_RATIO_W-1:0] pre_cnt;
  logic [NR_W-1:0]       post_cnt;
  logic                  pre_tick, pre_hi;
  logic                  post_wrap, post_hi;
  logic                  gate_q, gate_n;
  logic                  out_q, out_n;
  logic                  at_start, raw;

  cdv_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  cdv_apply_ctl #(.N1_W(N1_W)) u_ctl (
    .clk(clk), .rst_n(rst_sync_n), .apply(apply), .freeze(freeze),
    .hs_code(hs_code), .n1_code(n1_code), .commit(commit),
    .pend(apply_pend), .err(code_err), .hs_ratio(hs_ratio_q), .n1_ratio(n1_ratio_q)
  );

  cdv_stage_cnt #(.CW(HS_RATIO_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .restart(commit), .adv(1'b1),
    .ratio(hs_ratio_q), .cnt(pre_cnt), .wrap(pre_tick), .hi(pre_hi)
  );

  cdv_stage_cnt #(.CW(NR_W)) u_post (
    .clk(clk), .rst_n(rst_sync_n), .restart(commit), .adv(pre_tick),
    .ratio(n1_ratio_q), .cnt(post_cnt), .wrap(post_wrap), .hi(post_hi)
  );

  always_comb begin
    at_start = (pre_cnt == '0) && (post_cnt == '0);
    gate_n   = out_en & (gate_q | at_start);
    raw      = (n1_ratio_q == NR_W'(1)) ? pre_hi : post_hi;
    out_n    = gate_n & raw;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      gate_q <= gate_n;
      out_q  <= out_n;
    end
  end

  assign clk_out = out_q;
endmodule

// File: rtl/cdv_two_stage_chk.sv
`timescale 1ns/1ps
module cdv_two_stage_chk
  import cdv_pkg::*;
(
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic                  apply,
  input logic                  freeze,
  input logic                  out_en,
  input logic                  apply_pend,
  input logic                  code_err,
  input logic                  clk_out,
  input logic [HS_RATIO_W-1:0] pre_cnt,
  input logic [HS_RATIO_W-1:0] hs_ratio_q
);
  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    apply |=> apply_pend);
  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (apply_pend && !freeze && !apply) |=> !apply_pend);
  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (apply_pend && freeze) |=> apply_pend);
  // R8
  oe_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_en |=> !clk_out);
  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    code_err |=> code_err);
  // R1
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pre_cnt < hs_ratio_q);
  // R1
  ratio_legal_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hs_ratio_q == 4'd4) || (hs_ratio_q == 4'd5) || (hs_ratio_q == 4'd6) ||
    (hs_ratio_q == 4'd7) || (hs_ratio_q == 4'd9) || (hs_ratio_q == 4'd11));
endmodule

bind cdv_two_stage cdv_two_stage_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .apply(apply), .freeze(freeze),
  .out_en(out_en), .apply_pend(apply_pend), .code_err(code_err),
  .clk_out(clk_out), .pre_cnt(pre_cnt), .hs_ratio_q(hs_ratio_q)
);

// File: tb/cdv_two_stage_bench.sv
`timescale 1ns/1ps
module cdv_two_stage_bench;
  logic       clk;
  logic       rst_n;
  logic       out_en;
  logic       freeze;
  logic       apply;
  logic [2:0] hs_code;
  logic [6:0] n1_code;
  logic       clk_out;
  logic       apply_pend;
  logic       code_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  cdv_two_stage u_cdv_two_stage (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .freeze(freeze), .apply(apply),
    .hs_code(hs_code), .n1_code(n1_code), .clk_out(clk_out),
    .apply_pend(apply_pend), .code_err(code_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int hs_of(input logic [2:0] c);
    case (c)
      3'b000: return 4;
      3'b001: return 5;
      3'b010: return 6;
      3'b011: return 7;
      3'b101: return 9;
      3'b111: return 11;
      default: return 0;
    endcase
  endfunction

  function automatic int n1_of(input int f);
    int r = f + 1;
    if (r > 1 && (r % 2) == 1) r = r + 1;
    return r;
  endfunction

  function automatic int hi_of(input int r1, input int r2);
    if (r2 == 1) return r1 / 2;
    return r1 * r2 / 2;
  endfunction

  task automatic set_cfg(input logic [2:0] hc, input logic [6:0] nc);
    @(negedge clk);
    hs_code = hc; n1_code = nc; apply = 1'b1;
    @(negedge clk);
    apply = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Skips one period, then measures the next high and low phases.
  task automatic meas(input int eh, input int el, input string tag);
    int g = 0;
    int hi = 0;
    int lo = 0;
    while (clk_out !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
    while (clk_out !== 1'b1 && g < 5000) begin @(negedge clk); g++; end
    while (clk_out !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
    while (clk_out !== 1'b1 && g < 5000) begin @(negedge clk); g++; end
    while (clk_out === 1'b1 && hi < 5000) begin hi++; @(negedge clk); end
    while (clk_out === 1'b0 && lo < 5000) begin lo++; @(negedge clk); end
    check(hi == eh, {tag, " high"}, hi, eh);
    check(lo == el, {tag, " low"}, lo, el);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; out_en = 1'b1; freeze = 1'b0; apply = 1'b0;
    hs_code = 3'b000; n1_code = 7'd0;
    repeat (4) @(negedge clk);
    check(clk_out === 1'b0, "R10 clk_out in reset", int'(clk_out), 0);
    check(apply_pend === 1'b0, "R10 pend in reset", int'(apply_pend), 0);
    check(code_err === 1'b0, "R10 err in reset", int'(code_err), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    meas(2, 2, "R10 default ratio 4x1");
  endtask

  task automatic t_codes();
    logic [2:0] valid [6] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b101, 3'b111};
    for (int i = 0; i < 6; i++) begin
      int r = hs_of(valid[i]);
      set_cfg(valid[i], 7'd0);
      // R1 and R4: odd first-stage ratio gives a high phase one cycle short
      meas(r / 2, r - r / 2, $sformatf("R1 R4 code %0d", valid[i]));
    end
    check(code_err === 1'b0, "R2 no err on valid codes", int'(code_err), 0);
  endtask

  task automatic t_n1();
    int fields [5] = '{1, 2, 9, 126, 127};
    for (int i = 0; i < 5; i++) begin
      int r2 = n1_of(fields[i]);
      int h  = hi_of(4, r2);
      set_cfg(3'b000, 7'(fields[i]));
      // R3 and R4: even second-stage ratio gives equal phases
      meas(h, 4 * r2 - h, $sformatf("R3 R4 field %0d", fields[i]));
    end
    set_cfg(3'b001, 7'd3);
    meas(10, 10, "R4 odd first stage, even second stage");
  endtask

  task automatic t_no_apply();
    set_cfg(3'b000, 7'd1);
    @(negedge clk);
    hs_code = 3'b111; n1_code = 7'd20;
    repeat (5) @(negedge clk);
    meas(4, 4, "R5 codes changed without apply");
  endtask

  task automatic t_pend();
    @(negedge clk);
    hs_code = 3'b010; n1_code = 7'd0; apply = 1'b1;
    @(negedge clk);
    apply = 1'b0;
    check(apply_pend === 1'b1, "R6 pend after apply edge", int'(apply_pend), 1);
    @(negedge clk);
    check(apply_pend === 1'b0, "R6 pend cleared next edge", int'(apply_pend), 0);
    meas(3, 3, "R6 new setting active");
  endtask

  task automatic t_freeze();
    @(negedge clk);
    freeze = 1'b1;
    set_cfg(3'b011, 7'd1);
    check(apply_pend === 1'b1, "R7 pend held while frozen", int'(apply_pend), 1);
    meas(3, 3, "R7 output unchanged while frozen");
    set_cfg(3'b101, 7'd0);
    check(apply_pend === 1'b1, "R7 pend held after rewrite", int'(apply_pend), 1);
    @(negedge clk);
    freeze = 1'b0;
    @(negedge clk);
    check(apply_pend === 1'b0, "R7 pend cleared on release", int'(apply_pend), 0);
    meas(4, 5, "R7 last shadow applied on release");
  endtask

  task automatic t_invalid();
    set_cfg(3'b010, 7'd0);
    check(code_err === 1'b0, "R2 err clear before invalid", int'(code_err), 0);
    set_cfg(3'b100, 7'd1);
    check(code_err === 1'b1, "R2 err after code 100", int'(code_err), 1);
    meas(6, 6, "R2 ratio kept, second stage applied");
    set_cfg(3'b110, 7'd0);
    meas(3, 3, "R2 code 110 keeps ratio");
    set_cfg(3'b000, 7'd0);
    check(code_err === 1'b1, "R2 err sticky", int'(code_err), 1);
    meas(2, 2, "R2 valid code after error");
  endtask

  task automatic t_oe();
    int hi = 0;
    int g  = 0;
    bit low_ok = 1'b1;
    set_cfg(3'b011, 7'd3);
    @(negedge clk);
    out_en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      if (clk_out !== 1'b0) low_ok = 1'b0;
      @(negedge clk);
    end
    check(low_ok, "R8 output low while disabled", int'(low_ok), 1);
    repeat (9) @(negedge clk);
    out_en = 1'b1;
    while (clk_out !== 1'b1 && g < 200) begin @(negedge clk); g++; end
    while (clk_out === 1'b1 && hi < 200) begin hi++; @(negedge clk); end
    check(hi == 14, "R8 first pulse full after enable", hi, 14);
  endtask

  task automatic t_restart();
    set_cfg(3'b111, 7'd9);
    repeat (37) @(negedge clk);
    hs_code = 3'b000; n1_code = 7'd0; apply = 1'b1;
    @(negedge clk);
    apply = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(clk_out === 1'b1, "R9 high after restart", int'(clk_out), 1);
    @(negedge clk);
    check(clk_out === 1'b1, "R9 high second cycle", int'(clk_out), 1);
    @(negedge clk);
    check(clk_out === 1'b0, "R9 low after full phase", int'(clk_out), 0);
  endtask

  initial begin
    t_reset();
    t_codes();
    t_n1();
    t_no_apply();
    t_pend();
    t_freeze();
    t_invalid();
    t_oe();
    t_restart();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule